// File: doc/BRIEF.md
# Single-Operand ALU with Condition Flags

This unit performs the one-operand operations of a 16-bit minicomputer-style instruction set. Each operation runs in word mode or byte mode. The operations are clear, complement, increment, decrement, negate, add carry, subtract carry, rotate right, rotate left, arithmetic shift right, arithmetic shift left, swap bytes and sign-extend.

With each operation the caller presents the operand, the current condition flags, a bit that says whether the destination is a register, and the destination address. The unit returns the result, the new N, Z, V and C flags and a flag write enable. Operand fetch and write-back happen outside the block.

Each operation has its own flag rules. If the destination is in memory and its address equals the processor status word address (octal 177776 by default), the unit still returns the result but withholds every flag update.

The controller has two states. S_IDLE waits for `in_valid`. The transition S_IDLE to S_EXEC captures the request. The transition S_EXEC to S_IDLE, which is always taken after one cycle, registers the outputs and pulses `out_valid`.

Top module: `sop_alu`

## Requirements
- R1: After reset `out_valid`, `flag_we`, `result` and `flags_out` are all zero.
- R2: A request accepted in S_IDLE produces one single-cycle `out_valid` pulse two rising edges later. An `in_valid` seen while in S_EXEC is ignored and yields no second pulse.
- R3: Opcodes are 0 clear, 1 complement, 2 increment, 3 decrement, 4 negate, 5 add carry, 6 subtract carry, 7 rotate right, 8 rotate left, 9 arithmetic shift right, 10 arithmetic shift left, 11 swap, 12 sign-extend.
- R3 (continued): In byte mode (`byte_sel`=1), opcodes 0 to 10 use bits 7:0 only and return zero in the upper byte. For these operations N is the result's top bit for the width and Z tests the result over that width. Opcodes 13 to 15 return the operand unchanged with `flag_we`=0.
- R4: Clear returns zero with flags N=0, Z=1, V=0, C=0.
- R5: Complement inverts the operand, sets N and Z from the result, clears V and sets C.
- R6: Increment sets V when the result is the most negative value. Decrement sets V when the result is the most positive value. Both leave C unchanged.
- R7: Negate returns the two's complement, sets C when the result is nonzero and sets V when the result is the most negative value.
- R8: Add carry adds C. It sets V when the operand is the most positive value and C=1, and sets C when the operand is all ones and C=1. Subtract carry subtracts C. It sets V when the operand is the most negative value and C=1, and sets C when the operand is zero and C=1.
- R9: Rotates pass C through the vacated end. Arithmetic shift right repeats the sign bit. Arithmetic shift left fills with zero. Right moves shift bit 0 out into C, and left moves shift the old top bit out into C.
- R10: After each rotate or shift, V equals the new N XOR the new C.
- R11: Swap is always word wide and exchanges the bytes. N is the new bit 7, Z tests only the new low byte, and V and C are cleared.
- R12: Sign-extend is always word wide and returns all ones if N=1, else zero. It sets Z to NOT N, clears V and keeps N and C.
- R13: When `dst_is_reg`=0 and `dst_addr` equals the status address, `flag_we`=0 and `flags_out` equals `flags_in`, while `result` is still produced. A register destination never blocks.
- R14: Flags are ordered {N,Z,V,C} in bits [3:0]. When `flag_we`=1, `flags_out` carries the new flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, taken in S_IDLE |
| op | input | 4 | Operation code |
| byte_sel | input | 1 | 1 = byte mode |
| operand | input | DATA_W | Source operand |
| flags_in | input | 4 | Current {N,Z,V,C} |
| dst_is_reg | input | 1 | Destination is a register |
| dst_addr | input | ADDR_W | Destination memory address |
| out_valid | output | 1 | Result pulse |
| result | output | DATA_W | Operation result |
| flags_out | output | 4 | Flags after the operation |
| flag_we | output | 1 | Flags updated by this operation |

## Verification
Two functions can land in the same cycle: the per-operation flag computation and the status-address suppression. The bench provokes this by sending every opcode, in both widths and with every incoming flag pattern, to a memory destination at the status address. It judges the outcome by requiring the normal result together with `flags_out` equal to `flags_in` and `flag_we` low. Neighbouring addresses and register destinations at the same address must update the flags normally. A second overlap, a new request arriving during S_EXEC, is provoked back to back and judged by the presence of exactly one output pulse that carries the first request's result.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [3:0] {
        OP_CLR   = 4'd0,
        OP_COM   = 4'd1,
        OP_INC   = 4'd2,
        OP_DEC   = 4'd3,
        OP_NEG   = 4'd4,
        OP_ADC   = 4'd5,
        OP_SBC   = 4'd6,
        OP_ROR   = 4'd7,
        OP_ROL   = 4'd8,
        OP_ASR   = 4'd9,
        OP_ASL   = 4'd10,
        OP_SWB   = 4'd11,
        OP_SXT   = 4'd12,
        OP_RSV13 = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } sop_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } sop_flags_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EXEC = 1'b1
    } sop_state_e;

endpackage

// File: rtl/sop_datapath.sv
module sop_datapath
    import sop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  sop_op_e             op,
    input  logic                byte_mode,
    input  logic [DATA_W-1:0]   operand,
    input  logic                c_in,
    input  logic                n_in,
    output logic [DATA_W-1:0]   res,
    output logic [DATA_W-1:0]   mask,
    output logic [DATA_W-1:0]   sgn,
    output logic                sh_c
);
    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = 2;

    logic [DATA_W-1:0] xw;
    logic [DATA_W-1:0] cw;
    logic [DATA_W-1:0] raw;
    logic              msb_x;
    logic              width_op;

    // lane enables: the upper lane is live only in word mode
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign mask[l*HALF_W +: HALF_W] = (l == 0 || !byte_mode) ? {HALF_W{1'b1}} : {HALF_W{1'b0}};
    end

    assign sgn   = byte_mode ? {{(DATA_W-1){1'b0}}, 1'b1} << (HALF_W - 1)
                             : {{(DATA_W-1){1'b0}}, 1'b1} << (DATA_W - 1);
    assign xw    = operand & mask;
    assign cw    = {{(DATA_W-1){1'b0}}, c_in};
    assign msb_x = |(xw & sgn);

    always_comb begin
        raw      = operand;
        sh_c     = 1'b0;
        width_op = 1'b1;
        unique case (op)
            OP_CLR: raw = '0;
            OP_COM: raw = ~xw;
            OP_INC: raw = xw + {{(DATA_W-1){1'b0}}, 1'b1};
            OP_DEC: raw = xw - {{(DATA_W-1){1'b0}}, 1'b1};
            OP_NEG: raw = '0 - xw;
            OP_ADC: raw = xw + cw;
            OP_SBC: raw = xw - cw;
            OP_ROR: begin
                raw  = (xw >> 1) | (c_in ? sgn : '0);
                sh_c = xw[0];
            end
            OP_ROL: begin
                raw  = (xw << 1) | cw;
                sh_c = msb_x;
            end
            OP_ASR: begin
                raw  = (xw >> 1) | (xw & sgn);
                sh_c = xw[0];
            end
            OP_ASL: begin
                raw  = xw << 1;
                sh_c = msb_x;
            end
            OP_SWB: begin
                raw      = {operand[HALF_W-1:0], operand[DATA_W-1:HALF_W]};
                width_op = 1'b0;
            end
            OP_SXT: begin
                raw      = {DATA_W{n_in}};
                width_op = 1'b0;
            end
            OP_RSV13, OP_RSV14, OP_RSV15: begin
                raw      = operand;
                width_op = 1'b0;
            end
        endcase
        res = width_op ? (raw & mask) : raw;
    end

endmodule

// File: rtl/sop_flagcalc.sv
module sop_flagcalc
    import sop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  sop_op_e             op,
    input  logic [DATA_W-1:0]   operand,
    input  logic [DATA_W-1:0]   res,
    input  logic [DATA_W-1:0]   mask,
    input  logic [DATA_W-1:0]   sgn,
    input  logic                sh_c,
    input  sop_flags_t          f_in,
    output sop_flags_t          f_new
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] xw;
    logic [DATA_W-1:0] rw;
    logic [DATA_W-1:0] max_pos;
    logic              rn;
    logic              rz;

    assign xw      = operand & mask;
    assign rw      = res & mask;
    assign max_pos = mask & ~sgn;
    assign rn      = |(res & sgn);
    assign rz      = (rw == '0);

    always_comb begin
        f_new = f_in;
        unique case (op)
            OP_CLR: f_new = '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
            OP_COM: f_new = '{n: rn, z: rz, v: 1'b0, c: 1'b1};
            OP_INC: f_new = '{n: rn, z: rz, v: (rw == sgn), c: f_in.c};
            OP_DEC: f_new = '{n: rn, z: rz, v: (rw == max_pos), c: f_in.c};
            OP_NEG: f_new = '{n: rn, z: rz, v: (rw == sgn), c: !rz};
            OP_ADC: f_new = '{n: rn, z: rz,
                              v: (xw == max_pos) && f_in.c,
                              c: (xw == mask) && f_in.c};
            OP_SBC: f_new = '{n: rn, z: rz,
                              v: (xw == sgn) && f_in.c,
                              c: (xw == '0) && f_in.c};
            OP_ROR, OP_ROL, OP_ASR, OP_ASL:
                f_new = '{n: rn, z: rz, v: rn ^ sh_c, c: sh_c};
            OP_SWB: f_new = '{n: res[HALF_W-1], z: (res[HALF_W-1:0] == '0), v: 1'b0, c: 1'b0};
            OP_SXT: f_new = '{n: f_in.n, z: !f_in.n, v: 1'b0, c: f_in.c};
            OP_RSV13, OP_RSV14, OP_RSV15: f_new = f_in;
        endcase
    end

endmodule

// File: rtl/sop_guard.sv
module sop_guard #(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'o177776
) (
    input  logic               op_known,
    input  logic               dst_is_reg,
    input  logic [ADDR_W-1:0]  dst_addr,
    output logic               allow
);
    logic hits_status;

    assign hits_status = !dst_is_reg && (dst_addr == STATUS_ADDR);
    assign allow       = op_known && !hits_status;

endmodule

// File: rtl/sop_alu.sv
module sop_alu
    import sop_pkg::*;
#(
    parameter int                DATA_W      = 16,
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'o177776
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [3:0]         op,
    input  logic               byte_sel,
    input  logic [DATA_W-1:0]  operand,
    input  logic [3:0]         flags_in,
    input  logic               dst_is_reg,
    input  logic [ADDR_W-1:0]  dst_addr,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result,
    output logic [3:0]         flags_out,
    output logic               flag_we
);
    sop_state_e         state, state_nxt;
    sop_op_e            op_q;
    logic               byte_q;
    logic [DATA_W-1:0]  opnd_q;
    sop_flags_t         flags_q;
    logic               dreg_q;
    logic [ADDR_W-1:0]  addr_q;

    logic [DATA_W-1:0]  dp_res;
    logic [DATA_W-1:0]  dp_mask;
    logic [DATA_W-1:0]  dp_sgn;
    logic               dp_shc;
    sop_flags_t         fc_new;
    logic               allow;
    logic               take;

    assign take = (state == S_IDLE) && in_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (in_valid) state_nxt = S_EXEC;
            S_EXEC: state_nxt = S_IDLE;
        endcase
    end

    // request capture on the S_IDLE -> S_EXEC transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_CLR;
            byte_q  <= 1'b0;
            opnd_q  <= '0;
            flags_q <= '0;
            dreg_q  <= 1'b0;
            addr_q  <= '0;
        end else if (take) begin
            op_q    <= sop_op_e'(op);
            byte_q  <= byte_sel;
            opnd_q  <= operand;
            flags_q <= sop_flags_t'(flags_in);
            dreg_q  <= dst_is_reg;
            addr_q  <= dst_addr;
        end
    end

    sop_datapath #(.DATA_W(DATA_W)) u_dp (
        .op        (op_q),
        .byte_mode (byte_q),
        .operand   (opnd_q),
        .c_in      (flags_q.c),
        .n_in      (flags_q.n),
        .res       (dp_res),
        .mask      (dp_mask),
        .sgn       (dp_sgn),
        .sh_c      (dp_shc)
    );

    sop_flagcalc #(.DATA_W(DATA_W)) u_fc (
        .op      (op_q),
        .operand (opnd_q),
        .res     (dp_res),
        .mask    (dp_mask),
        .sgn     (dp_sgn),
        .sh_c    (dp_shc),
        .f_in    (flags_q),
        .f_new   (fc_new)
    );

    sop_guard #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_guard (
        .op_known   (op_q <= OP_SXT),
        .dst_is_reg (dreg_q),
        .dst_addr   (addr_q),
        .allow      (allow)
    );

    // output register, loaded on the S_EXEC -> S_IDLE transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags_out <= '0;
            flag_we   <= 1'b0;
        end else begin
            out_valid <= (state == S_EXEC);
            flag_we   <= (state == S_EXEC) && allow;
            if (state == S_EXEC) begin
                result    <= dp_res;
                flags_out <= allow ? 4'(fc_new) : 4'(flags_q);
            end
        end
    end

    // one pulse per request
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_pulse_after_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state == S_EXEC));

    assert_status_block_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && !dreg_q && addr_q == STATUS_ADDR)
        |=> (!flag_we && flags_out == $past(4'(flags_q))));

    assert_clear_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && op_q == OP_CLR && allow) |=> (flags_out == 4'b0100 && result == '0));

    assert_carry_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && (op_q == OP_INC || op_q == OP_DEC))
        |=> (flags_out[0] == $past(flags_q.c)));

    assert_shift_v_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && allow && op_q inside {OP_ROR, OP_ROL, OP_ASR, OP_ASL})
        |=> (flags_out[1] == (flags_out[3] ^ flags_out[0])));

    assert_sxt_fill_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && op_q == OP_SXT) |=> (result == {DATA_W{$past(flags_q.n)}}));

endmodule

// File: tb/sop_alu_tb.sv
`timescale 1ns/100ps
module sop_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        byte_sel = 1'b0;
    logic [15:0] operand = '0;
    logic [3:0]  flags_in = '0;
    logic        dst_is_reg = 1'b1;
    logic [15:0] dst_addr = '0;
    logic        out_valid;
    logic [15:0] result;
    logic [3:0]  flags_out;
    logic        flag_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [15:0] PSW_ADDR = 16'o177776;

    always #2.5 clk = ~clk;

    sop_alu dut_i (
        .clk, .rst_n, .in_valid, .op, .byte_sel, .operand, .flags_in,
        .dst_is_reg, .dst_addr, .out_valid, .result, .flags_out, .flag_we
    );

    function automatic string req_of(input int o);
        case (o)
            0: return "R4";
            1: return "R5";
            2, 3: return "R6";
            4: return "R7";
            5, 6: return "R8";
            7, 8, 9, 10: return "R9/R10";
            11: return "R11";
            12: return "R12";
            default: return "R3";
        endcase
    endfunction

    // reference computed arithmetically from the requirements
    function automatic void model(input int o, input bit bm, input int x, input bit [3:0] fi,
                                  input bit blocked, output int r, output bit [3:0] fo, output bit we);
        int w, m, sg, xv;
        bit n, z, v, c;
        w  = bm ? 8 : 16;
        m  = (1 << w) - 1;
        sg = 1 << (w - 1);
        xv = x & m;
        n = fi[3]; z = fi[2]; v = fi[1]; c = fi[0];
        r = x & 16'hFFFF;
        case (o)
            0:  begin r = 0; n = 0; z = 1; v = 0; c = 0; end
            1:  begin r = ~xv & m; v = 0; c = 1; end
            2:  begin r = (xv + 1) & m; v = (r == sg); end
            3:  begin r = (xv - 1) & m; v = (r == sg - 1); end
            4:  begin r = (-xv) & m; v = (r == sg); c = (r != 0); end
            5:  begin r = (xv + int'(fi[0])) & m; v = (xv == sg - 1) && fi[0]; c = (xv == m) && fi[0]; end
            6:  begin r = (xv - int'(fi[0])) & m; v = (xv == sg) && fi[0]; c = (xv == 0) && fi[0]; end
            7:  begin r = (xv >> 1) | (fi[0] ? sg : 0); c = xv[0]; end
            8:  begin r = ((xv << 1) & m) | int'(fi[0]); c = (xv & sg) != 0; end
            9:  begin r = (xv >> 1) | (xv & sg); c = xv[0]; end
            10: begin r = (xv << 1) & m; c = (xv & sg) != 0; end
            11: begin r = ((x & 255) << 8) | ((x >> 8) & 255); end
            12: begin r = fi[3] ? 16'hFFFF : 0; end
            default: ;
        endcase
        if (o >= 1 && o <= 10) begin
            n = (r & sg) != 0;
            z = (r == 0);
        end
        if (o >= 7 && o <= 10) v = n ^ c;
        if (o == 11) begin n = (r & 128) != 0; z = (r & 255) == 0; v = 0; c = 0; end
        if (o == 12) begin z = !fi[3]; v = 0; end
        we = (o <= 12) && !blocked;
        fo = we ? {n, z, v, c} : fi;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input int o, input bit bm, input int x, input bit [3:0] fi,
                           input bit dreg, input logic [15:0] addr);
        int r; bit [3:0] fo; bit we; bit blk;
        string rq;
        blk = !dreg && (addr == PSW_ADDR);
        model(o, bm, x, fi, blk, r, fo, we);
        rq = blk ? {req_of(o), "+R13"} : req_of(o);
        @(negedge clk);
        in_valid = 1'b1; op = 4'(o); byte_sel = bm; operand = 16'(x);
        flags_in = fi; dst_is_reg = dreg; dst_addr = addr;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        if (!out_valid || result != 16'(r) || flags_out != fo || flag_we != we) begin
            check("R2", "out_valid", int'(out_valid), 1);
            check(rq, $sformatf("result op%0d bm%0d x%0h f%0h", o, bm, x, fi), int'(result), r);
            check({rq, "/R14"}, $sformatf("flags op%0d bm%0d x%0h f%0h", o, bm, x, fi), int'(flags_out), int'(fo));
            check(rq, "flag_we", int'(flag_we), int'(we));
        end else begin
            checks++;
        end
    endtask

    initial begin
        int vals[12] = '{0, 1, 'h7F, 'h80, 'hFF, 'h100, 'h7FFF, 'h8000, 'hFFFF, 'h1234, 'hA5C3, 'hFE};
        int k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "flag_we", int'(flag_we), 0);
        check("R1", "result", int'(result), 0);
        check("R1", "flags_out", int'(flags_out), 0);

        // sweep every opcode, width, operand and flag pattern; destination rotates
        for (int o = 0; o < 16; o++)
            for (int bm = 0; bm < 2; bm++)
                for (int vi = 0; vi < 12; vi++)
                    for (int f = 0; f < 16; f++) begin
                        logic [15:0] a;
                        bit dr;
                        k++;
                        a  = (k % 3 == 0) ? PSW_ADDR : 16'(k * 37);
                        dr = (k % 5 == 0);
                        run_one(o, bit'(bm), vals[vi], 4'(f), dr, a);
                    end

        // R13 boundaries: neighbours and register destination do not block
        run_one(4, 1'b0, 'h0005, 4'h0, 1'b0, PSW_ADDR);
        run_one(4, 1'b0, 'h0005, 4'h0, 1'b0, 16'o177774);
        run_one(4, 1'b0, 'h0005, 4'h0, 1'b0, 16'o177777);
        run_one(0, 1'b0, 'h1111, 4'hF, 1'b1, PSW_ADDR);
        run_one(0, 1'b0, 'h1111, 4'hB, 1'b0, PSW_ADDR);

        // R2: second request during S_EXEC is ignored
        @(negedge clk);
        in_valid = 1'b1; op = 4'd0; byte_sel = 1'b0; operand = 16'h5555;
        flags_in = 4'h0; dst_is_reg = 1'b1; dst_addr = '0;
        check("R2", "no early pulse", int'(out_valid), 0);
        @(negedge clk);
        op = 4'd1;
        check("R2", "exec cycle pulse", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "pulse", int'(out_valid), 1);
        check("R2", "first result kept", int'(result), 0);
        @(negedge clk);
        check("R2", "ignored request", int'(out_valid), 0);
        @(negedge clk);
        check("R2", "still idle", int'(out_valid), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule